// File: doc/BRIEF.md
# Multi-Page-Size Set-Associative TLB

This block is a second-level translation cache that holds recently used virtual-to-physical page translations for three page sizes: 4 KiB small pages, 64 KiB large pages and 1 MiB sections. Storage is arranged as sets of ways, 64 sets by 8 ways by default. Each page size has its own rule for which sets may hold an entry. A small page is tied to exactly one set. A large page may use one of the 16 sets that share two fixed index bits. A section may use any set.

A client presents a virtual page number on the lookup port. One cycle later the block returns hit or miss, the physical page number and the page size. On a hit, the untranslated low bits of the virtual page number pass straight into the physical page number. The page walker installs translations through the fill port. Software-directed maintenance uses two inputs. Invalidate-by-address walks every set the target could occupy, one set per cycle, and holds busy while the walk runs. Flush clears every entry in one cycle.

Top module: `l2_tlb`

## Requirements
- R1: A lookup accepted in cycle t returns rsp_valid in cycle t+1, with rsp_hit, rsp_ppn and rsp_size taken from the stored translation. After reset, busy and rsp_valid are low and every lookup misses.
- R2: A small-page translation (size code 2'b00) is stored in the set whose index is vpn[5:0]. Translations of other sets never displace it.
- R3: A large-page translation (size code 2'b01) is stored in set {vpn[5:4], vpn[9:6]}. It hits for all 16 virtual page numbers sharing vpn[19:4].
- R4: A section translation (size code 2'b10) is stored in set vpn[13:8]. It hits for all 256 virtual page numbers sharing vpn[19:8]. A fill with size code 2'b11 has no effect.
- R5: On a hit, rsp_ppn is the stored frame with its offset bits replaced by the lookup's own bits: none for a small page, vpn[3:0] for a large page, vpn[7:0] for a section.
- R6: A fill writes the lowest-numbered invalid way of its set. When the set is full it replaces the least recently used way, where both fills and lookup hits count as uses.
- R7: An invalidate with size code 2'b00 holds busy for exactly 1 cycle. It removes only entries whose page covers the given address.
- R8: An invalidate with size code 2'b01 holds busy for 16 cycles. It sweeps every set whose index bits [5:4] equal vpn[5:4], removing entries that cover the address.
- R9: An invalidate with size code 2'b10 or 2'b11 holds busy for 64 cycles and sweeps every set. Entries that do not cover the address survive.
- R10: While busy is high, lookups produce no response and fills are discarded.
- R11: Asserting flush_all for one cycle invalidates every entry. A lookup in the following cycle misses. A lookup or fill presented together with flush_all is discarded.
- R12: When fill_valid and lk_valid are high in the same cycle, the fill is performed and the lookup is dropped without a response.
- R13: When entries of several sizes cover the looked-up address, the smallest page size wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number of the installed page |
| fill_pfn | input | 20 | Physical page number of the installed page |
| fill_size | input | 2 | Page size code of the fill |
| inv_valid | input | 1 | Start an invalidate-by-address |
| inv_vpn | input | 20 | Address whose translations are removed |
| inv_size | input | 2 | Page size code selecting the sweep range |
| flush_all | input | 1 | Invalidate every entry in one cycle |
| busy | output | 1 | Invalidate sweep in progress |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | 20 | Translated physical page number |
| rsp_size | output | 2 | Page size code of the hitting entry |

## Verification
The bench keeps the default 64 sets but builds the block with 4 ways. A set then fills after four installs, so a fifth install must evict the least recently used way, with a lookup hit in between reordering the ages. The full 64-set sweep and the 16-set large-page sweep are measured cycle by cycle against busy. Stimulus during a sweep checks that lookups and fills are discarded. Overlapping small, large and section entries exercise the size priority and the offset pass-through.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int PN_W     = 20;
    localparam int LARGE_SH = 4;
    localparam int SECT_SH  = 8;

    typedef logic [1:0] pgsz_t;
    localparam pgsz_t SZ_SMALL = 2'b00;
    localparam pgsz_t SZ_LARGE = 2'b01;
    localparam pgsz_t SZ_SECT  = 2'b10;

    typedef struct packed {
        logic [PN_W-1:0] vpn;
        logic [PN_W-1:0] pfn;
        pgsz_t           size;
    } tlb_ent_t;

    // Ones over the frame bits, zeros over the in-page offset bits.
    function automatic logic [PN_W-1:0] frame_mask(pgsz_t sz);
        logic [PN_W-1:0] m;
        m = '1;
        case (sz)
            SZ_SMALL: m = '1;
            SZ_LARGE: m = m << LARGE_SH;
            default:  m = m << SECT_SH;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/tlb_set_sel.sv
module tlb_set_sel
    import tlb_pkg::*;
#(
    parameter int SET_W    = 6,
    parameter int LG_FIX_W = 2
) (
    input  logic [PN_W-1:0]  vpn,
    output logic [SET_W-1:0] small_set,
    output logic [SET_W-1:0] large_set,
    output logic [SET_W-1:0] sect_set
);
    localparam int LG_FREE_W = SET_W - LG_FIX_W;

    assign small_set = vpn[SET_W-1:0];
    assign large_set = {vpn[SET_W-1 -: LG_FIX_W], vpn[SET_W +: LG_FREE_W]};
    assign sect_set  = vpn[SECT_SH +: SET_W];
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int NSETS = 64,
    parameter int NWAYS = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     touch_en,
    input  logic [$clog2(NSETS)-1:0] touch_set,
    input  logic [$clog2(NWAYS)-1:0] touch_way,
    input  logic [$clog2(NSETS)-1:0] q_set,
    output logic [$clog2(NWAYS)-1:0] victim
);
    localparam int WAY_W = $clog2(NWAYS);

    // Per-way age: 0 = most recent, NWAYS-1 = least recent.
    logic [WAY_W-1:0] age [NSETS][NWAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSETS; s++)
                for (int w = 0; w < NWAYS; w++)
                    age[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < NWAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age[touch_set][w] <= '0;
                else if (age[touch_set][w] < age[touch_set][touch_way])
                    age[touch_set][w] <= age[touch_set][w] + 1'b1;
            end
        end
    end

    always_comb begin
        victim = '0;
        for (int w = 0; w < NWAYS; w++)
            if (age[q_set][w] == WAY_W'(NWAYS - 1))
                victim = WAY_W'(w);
    end
endmodule

// File: rtl/tlb_inv_seq.sv
module tlb_inv_seq
    import tlb_pkg::*;
#(
    parameter int SET_W    = 6,
    parameter int LG_FIX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cancel,
    input  logic             start,
    input  logic [PN_W-1:0]  start_vpn,
    input  pgsz_t            start_size,
    output logic             busy,
    output logic [SET_W-1:0] cur_set,
    output logic [PN_W-1:0]  tgt_vpn
);
    localparam int LG_FREE_W = SET_W - LG_FIX_W;

    logic [SET_W-1:0] cnt, last;
    pgsz_t            size_q;

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy    <= 1'b1;
            cnt     <= '0;
            tgt_vpn <= start_vpn;
            size_q  <= start_size;
            case (start_size)
                SZ_SMALL: last <= '0;
                SZ_LARGE: last <= SET_W'((1 << LG_FREE_W) - 1);
                default:  last <= '1;
            endcase
        end else if (busy) begin
            if (cnt == last) busy <= 1'b0;
            else             cnt  <= cnt + 1'b1;
        end
    end

    always_comb begin
        case (size_q)
            SZ_SMALL: cur_set = tgt_vpn[SET_W-1:0];
            SZ_LARGE: cur_set = {tgt_vpn[SET_W-1 -: LG_FIX_W], cnt[LG_FREE_W-1:0]};
            default:  cur_set = cnt;
        endcase
    end
endmodule

// File: rtl/l2_tlb.sv
module l2_tlb
    import tlb_pkg::*;
#(
    parameter int NSETS    = 64,
    parameter int NWAYS    = 8,
    parameter int LG_FIX_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lk_valid,
    input  logic [PN_W-1:0] lk_vpn,
    input  logic            fill_valid,
    input  logic [PN_W-1:0] fill_vpn,
    input  logic [PN_W-1:0] fill_pfn,
    input  logic [1:0]      fill_size,
    input  logic            inv_valid,
    input  logic [PN_W-1:0] inv_vpn,
    input  logic [1:0]      inv_size,
    input  logic            flush_all,
    output logic            busy,
    output logic            rsp_valid,
    output logic            rsp_hit,
    output logic [PN_W-1:0] rsp_ppn,
    output logic [1:0]      rsp_size
);
    localparam int SET_W = $clog2(NSETS);
    localparam int WAY_W = $clog2(NWAYS);
    localparam int NSZ   = 3;

    logic [NWAYS-1:0] vld [NSETS];
    tlb_ent_t         ent [NSETS][NWAYS];

    // Candidate sets for lookup (index = size code) and for fill
    logic [SET_W-1:0] lk_set [NSZ];
    logic [SET_W-1:0] fl_small, fl_large, fl_sect, fset;

    tlb_set_sel #(.SET_W(SET_W), .LG_FIX_W(LG_FIX_W)) u_lk_sel (
        .vpn(lk_vpn), .small_set(lk_set[0]), .large_set(lk_set[1]), .sect_set(lk_set[2]));
    tlb_set_sel #(.SET_W(SET_W), .LG_FIX_W(LG_FIX_W)) u_fl_sel (
        .vpn(fill_vpn), .small_set(fl_small), .large_set(fl_large), .sect_set(fl_sect));

    // Lookup: probe every size's set; smallest size, then lowest way, wins.
    logic             hit_any;
    logic [SET_W-1:0] hset;
    logic [WAY_W-1:0] hway;
    tlb_ent_t         hent;

    always_comb begin
        hit_any = 1'b0;
        hset    = '0;
        hway    = '0;
        hent    = '0;
        for (int s = NSZ - 1; s >= 0; s--) begin
            for (int w = NWAYS - 1; w >= 0; w--) begin
                if (vld[lk_set[s]][w] && ent[lk_set[s]][w].size == pgsz_t'(s) &&
                    (lk_vpn & frame_mask(ent[lk_set[s]][w].size)) == ent[lk_set[s]][w].vpn) begin
                    hit_any = 1'b1;
                    hset    = lk_set[s];
                    hway    = WAY_W'(w);
                    hent    = ent[lk_set[s]][w];
                end
            end
        end
    end

    // Fill target: first invalid way, else LRU victim
    logic             free_found;
    logic [WAY_W-1:0] free_way, lru_way, fway;

    always_comb begin
        case (fill_size)
            SZ_SMALL: fset = fl_small;
            SZ_LARGE: fset = fl_large;
            default:  fset = fl_sect;
        endcase
        free_found = 1'b0;
        free_way   = '0;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (!vld[fset][w]) begin
                free_found = 1'b1;
                free_way   = WAY_W'(w);
            end
        end
        fway = free_found ? free_way : lru_way;
    end

    // Acceptance
    logic idle_ok, do_fill, do_look, do_inv;
    assign idle_ok = !busy && !flush_all;
    assign do_fill = idle_ok && fill_valid && fill_size != 2'b11;
    assign do_look = idle_ok && lk_valid && !fill_valid;
    assign do_inv  = idle_ok && inv_valid;

    logic             touch_en;
    logic [SET_W-1:0] touch_set;
    logic [WAY_W-1:0] touch_way;
    assign touch_en  = do_fill || (do_look && hit_any);
    assign touch_set = do_fill ? fset : hset;
    assign touch_way = do_fill ? fway : hway;

    tlb_lru #(.NSETS(NSETS), .NWAYS(NWAYS)) u_lru (
        .clk(clk), .rst(rst), .touch_en(touch_en), .touch_set(touch_set),
        .touch_way(touch_way), .q_set(fset), .victim(lru_way));

    logic [SET_W-1:0] sw_set;
    logic [PN_W-1:0]  sw_vpn;

    tlb_inv_seq #(.SET_W(SET_W), .LG_FIX_W(LG_FIX_W)) u_inv (
        .clk(clk), .rst(rst), .cancel(flush_all), .start(do_inv),
        .start_vpn(inv_vpn), .start_size(inv_size), .busy(busy),
        .cur_set(sw_set), .tgt_vpn(sw_vpn));

    // Valid bits
    always_ff @(posedge clk) begin
        if (rst || flush_all) begin
            for (int s = 0; s < NSETS; s++) vld[s] <= '0;
        end else begin
            if (busy) begin
                for (int w = 0; w < NWAYS; w++)
                    if ((sw_vpn & frame_mask(ent[sw_set][w].size)) == ent[sw_set][w].vpn)
                        vld[sw_set][w] <= 1'b0;
            end
            if (do_fill) vld[fset][fway] <= 1'b1;
        end
    end

    // Entry payload (no reset needed: guarded by valid bits)
    always_ff @(posedge clk) begin
        if (do_fill) begin
            ent[fset][fway].vpn  <= fill_vpn & frame_mask(fill_size);
            ent[fset][fway].pfn  <= fill_pfn & frame_mask(fill_size);
            ent[fset][fway].size <= fill_size;
        end
    end

    // Response
    logic [PN_W-1:0] hmask;
    assign hmask = frame_mask(hent.size);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_ppn   <= '0;
            rsp_size  <= '0;
        end else begin
            rsp_valid <= do_look;
            rsp_hit   <= do_look && hit_any;
            rsp_ppn   <= hit_any ? ((hent.pfn & hmask) | (lk_vpn & ~hmask)) : '0;
            rsp_size  <= hit_any ? hent.size : SZ_SMALL;
        end
    end
endmodule

// File: rtl/l2_tlb_chk.sv
module l2_tlb_chk
    import tlb_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            lk_valid,
    input logic [PN_W-1:0] lk_vpn,
    input logic            fill_valid,
    input logic            inv_valid,
    input logic [1:0]      inv_size,
    input logic            flush_all,
    input logic            busy,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic [PN_W-1:0] rsp_ppn,
    input logic [1:0]      rsp_size
);
    a_r1_resp_follows_lookup: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(lk_valid));

    a_r1_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);

    a_r5_section_offset: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit && rsp_size == SZ_SECT) |-> rsp_ppn[7:0] == $past(lk_vpn[7:0]));

    a_r5_large_offset: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit && rsp_size == SZ_LARGE) |-> rsp_ppn[3:0] == $past(lk_vpn[3:0]));

    a_r7_small_sweep_one: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && !busy && !flush_all && inv_size == SZ_SMALL) |=> busy ##1 !busy);

    a_r10_stall_no_resp: assert property (@(posedge clk) disable iff (rst)
        (busy && lk_valid) |=> !rsp_valid);

    a_r11_flush_then_miss: assert property (@(posedge clk) disable iff (rst)
        flush_all ##1 (lk_valid && !fill_valid && !flush_all && !busy) |=> (rsp_valid && !rsp_hit));

    a_r12_fill_drops_lookup: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && lk_valid) |=> !rsp_valid);
endmodule

bind l2_tlb l2_tlb_chk u_chk (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .fill_valid(fill_valid), .inv_valid(inv_valid), .inv_size(inv_size),
    .flush_all(flush_all), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_size(rsp_size));

// File: tb/l2_tlb_test.sv
`timescale 1ns/1ps
module l2_tlb_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0, fill_valid = 1'b0, inv_valid = 1'b0, flush_all = 1'b0;
    logic [19:0] lk_vpn = '0, fill_vpn = '0, fill_pfn = '0, inv_vpn = '0;
    logic [1:0]  fill_size = '0, inv_size = '0;
    logic        busy, rsp_valid, rsp_hit;
    logic [19:0] rsp_ppn;
    logic [1:0]  rsp_size;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    typedef struct {
        logic        hit;
        logic [19:0] ppn;
        logic [1:0]  size;
        string       req;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    l2_tlb #(.NSETS(64), .NWAYS(4)) uut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_size(fill_size), .inv_valid(inv_valid), .inv_vpn(inv_vpn),
        .inv_size(inv_size), .flush_all(flush_all), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_size(rsp_size));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare responses against the scoreboard queue
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R10/R12", "unexpected response", 32'(rsp_ppn), 32'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(rsp_hit == e.hit, e.req, "hit", 32'(rsp_hit), 32'(e.hit));
                if (e.hit) begin
                    check(rsp_ppn == e.ppn, e.req, "ppn", 32'(rsp_ppn), 32'(e.ppn));
                    check(rsp_size == e.size, e.req, "size", 32'(rsp_size), 32'(e.size));
                end
            end
        end
    end

    task automatic lookup(input logic [19:0] vpn, input logic hit,
                          input logic [19:0] ppn, input logic [1:0] sz, input string req);
        exp_t e;
        @(negedge clk);
        e.hit = hit; e.ppn = ppn; e.size = sz; e.req = req;
        q.push_back(e);
        lk_valid = 1'b1; lk_vpn = vpn;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [1:0] sz);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_size = sz;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic inval(input logic [19:0] vpn, input logic [1:0] sz,
                         input int exp_cyc, input string req);
        int n;
        @(negedge clk);
        inv_valid = 1'b1; inv_vpn = vpn; inv_size = sz;
        @(negedge clk);
        inv_valid = 1'b0;
        n = 0;
        while (busy && n < 200) begin
            n++;
            @(negedge clk);
        end
        check(n == exp_cyc, req, "busy cycles", 32'(n), 32'(exp_cyc));
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1", "busy after reset", 32'(busy), 0);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 0);
        lookup(20'h00000, 0, 0, 0, "R1");

        // R2: small page
        fill(20'h00123, 20'h0AB00, 2'b00);
        lookup(20'h00123, 1, 20'h0AB00, 2'b00, "R2");
        lookup(20'h00124, 0, 0, 0, "R2");

        // R3 / R5: large page with offset pass-through
        fill(20'h04560, 20'h77770, 2'b01);
        lookup(20'h0456B, 1, 20'h7777B, 2'b01, "R3");
        lookup(20'h04570, 0, 0, 0, "R3");

        // R4 / R5: section
        fill(20'h12300, 20'h45600, 2'b10);
        lookup(20'h123A5, 1, 20'h456A5, 2'b10, "R5");
        lookup(20'h12400, 0, 0, 0, "R4");
        fill(20'h00900, 20'h33300, 2'b11);      // R4: reserved size ignored
        lookup(20'h00900, 0, 0, 0, "R4");

        // R13: small beats section on the same address
        fill(20'h123A5, 20'h00999, 2'b00);
        lookup(20'h123A5, 1, 20'h00999, 2'b00, "R13");
        lookup(20'h123A6, 1, 20'h456A6, 2'b10, "R13");

        // R6: LRU within set 5 (4 ways)
        fill(20'h00005, 20'h0A005, 2'b00);
        fill(20'h00045, 20'h0A045, 2'b00);
        fill(20'h00085, 20'h0A085, 2'b00);
        fill(20'h000C5, 20'h0A0C5, 2'b00);
        lookup(20'h00005, 1, 20'h0A005, 2'b00, "R6");
        fill(20'h00105, 20'h0A105, 2'b00);
        lookup(20'h00045, 0, 0, 0, "R6");
        lookup(20'h00005, 1, 20'h0A005, 2'b00, "R6");
        lookup(20'h00085, 1, 20'h0A085, 2'b00, "R6");
        lookup(20'h000C5, 1, 20'h0A0C5, 2'b00, "R6");
        lookup(20'h00105, 1, 20'h0A105, 2'b00, "R6");
        lookup(20'h00123, 1, 20'h0AB00, 2'b00, "R2");

        // R7: small invalidate
        inval(20'h00085, 2'b00, 1, "R7");
        lookup(20'h00085, 0, 0, 0, "R7");
        lookup(20'h000C5, 1, 20'h0A0C5, 2'b00, "R7");

        // R8: large invalidate
        inval(20'h04563, 2'b01, 16, "R8");
        lookup(20'h0456B, 0, 0, 0, "R8");
        lookup(20'h123A5, 1, 20'h00999, 2'b00, "R8");

        // R9 / R10: section sweep with stimulus during busy
        @(negedge clk);
        inv_valid = 1'b1; inv_vpn = 20'h12345; inv_size = 2'b10;
        @(negedge clk);
        inv_valid = 1'b0;
        lk_valid = 1'b1; lk_vpn = 20'h00005;
        fill_valid = 1'b1; fill_vpn = 20'h00777; fill_pfn = 20'h00333; fill_size = 2'b00;
        n = 0;
        while (busy && n < 200) begin
            n++;
            @(negedge clk);
            lk_valid = 1'b0;
            fill_valid = 1'b0;
        end
        lk_valid = 1'b0;
        fill_valid = 1'b0;
        check(n == 64, "R9", "busy cycles", 32'(n), 64);
        lookup(20'h123A6, 0, 0, 0, "R9");
        lookup(20'h123A5, 1, 20'h00999, 2'b00, "R9");
        lookup(20'h00777, 0, 0, 0, "R10");

        // R12: fill wins, lookup dropped
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = 20'h00888; fill_pfn = 20'h11111; fill_size = 2'b00;
        lk_valid = 1'b1; lk_vpn = 20'h00005;
        @(negedge clk);
        fill_valid = 1'b0; lk_valid = 1'b0;
        lookup(20'h00888, 1, 20'h11111, 2'b00, "R12");

        // R11: flush
        @(negedge clk);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        begin
            exp_t e;
            e.hit = 0; e.ppn = 0; e.size = 0; e.req = "R11";
            q.push_back(e);
        end
        lk_valid = 1'b1; lk_vpn = 20'h00005;
        @(negedge clk);
        lk_valid = 1'b0;
        check(busy == 1'b0, "R11", "busy after flush", 32'(busy), 0);
        lookup(20'h00888, 0, 0, 0, "R11");

        repeat (4) @(negedge clk);
        check(q.size() == 0, "R1", "missing responses", 32'(q.size()), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule